// File: doc/BRIEF.md
# Transmit End-of-Packet Qualifier with SE0 Glitch Rejection

This block sits between a PHY's two-bit line state and the transmit sequencer of a USB port. While the port is sending, it watches the line for the single-ended-zero (SE0) condition that marks end-of-packet. It reports the accepted end-of-packet with a one-cycle pulse and drops a transmit-busy flag, so the sequencer does not launch the next packet while the PHY is still driving the previous one.

The D+ and D- line-state bits can reach the controller with a few nanoseconds of skew. That skew is shorter than one line-state sample period, but it can still make a single sample read as SE0 in the middle of a packet. A control bit turns on a filter that accepts an end-of-packet only after SE0 appears on two consecutive clock edges. The filter is used only where this glitch matters. In host role it covers full-speed and low-speed ports. In device role it covers a full-speed port during a link-power-management handshake. Everywhere else, the first SE0 sample ends the packet.

Top module: `tx_eop_qualifier`

## Requirements
- R1: While reset is asserted, and after it is released, `eop_pulse` and `tx_busy` are 0 and the SE0 history is empty.
- R2: A rising edge of `tx_active`, sampled at a clock edge, sets `tx_busy` at that same edge. SE0 sampling for the packet starts at the next edge.
- R3: When the filter is not in effect, the first SE0 sample (`line_st` = 2'b00) taken while `tx_busy` is 1 produces `eop_pulse`.
- R4: When the filter is in effect, a single SE0 sample followed by a non-SE0 sample produces no `eop_pulse`, and `tx_busy` stays 1.
- R5: When the filter is in effect, SE0 sampled on two consecutive edges while busy produces `eop_pulse` at the second edge.
- R6: A non-SE0 sample (J = 2'b01 or K = 2'b10) between SE0 samples restarts the count, so separate single-sample glitches never add up to an end-of-packet.
- R7: SE1 (`line_st` = 2'b11) never counts as SE0.
- R8: In host role (`host_role` = 1), the filter is in effect at full speed (`bus_speed` = 2'b00) and at low speed (2'b01), and not at high speed (2'b10) or with the reserved code 2'b11.
- R9: In device role (`host_role` = 0), the filter is in effect only when `bus_speed` is 2'b00 and `lpm_hs` is 1.
- R10: The filter is enabled by bit 29 of `ctrl_word`. No other bit of `ctrl_word` has any effect.
- R11: `eop_pulse` lasts exactly one cycle, and `tx_busy` clears at the same edge that raises it.
- R12: SE0 on the line while `tx_busy` is 0 produces no `eop_pulse` and does not set `tx_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-state sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_st | input | 2 | Line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| tx_active | input | 1 | High while the port transmits; its rising edge starts a packet |
| host_role | input | 1 | 1 = host role, 0 = device role |
| bus_speed | input | 2 | 00 full, 01 low, 10 high, 11 reserved |
| lpm_hs | input | 1 | Link-power-management handshake in progress |
| ctrl_word | input | 32 | Control word; bit 29 enables the SE0 filter |
| eop_pulse | output | 1 | One-cycle pulse when end-of-packet is accepted |
| tx_busy | output | 1 | Packet in flight, from transmit start until end-of-packet |

## Verification
The bench builds the block with its defaults: a two-sample SE0 run, a 32-bit control word and the enable at bit 29. With these defaults, every combination of enable, role, all four speed codes and the handshake flag can be swept against every three-sample sequence of the four line codes. The sweep therefore covers every way an isolated SE0, a repeated SE0, SE1 and an interrupting J or K can be ordered under each filter decision. The other control-word bits are filled with a changing pattern, so any dependence on them would show up. Directed cases cover idle-line SE0 and each role/speed corner.

// File: rtl/eopq_pkg.sv
package eopq_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_state_e;

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_LOW  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_RSVD = 2'b11
  } bus_speed_e;

endpackage

// File: rtl/eopq_rst_sync.sv
module eopq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/eopq_policy.sv
module eopq_policy
  import eopq_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int FILT_BIT = 29
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              host_role,
  input  logic [1:0]        bus_speed,
  input  logic              lpm_hs,
  output logic              filt_active
);

  localparam logic [CTRL_W-1:0] FILT_MASK = {{(CTRL_W-1){1'b0}}, 1'b1} << FILT_BIT;

  logic filt_enabled;
  logic host_case;
  logic dev_case;
  logic unused_ctrl_bits;

  assign filt_enabled     = |(ctrl_word & FILT_MASK);
  assign unused_ctrl_bits = ^(ctrl_word & ~FILT_MASK);

  always_comb begin
    host_case   = host_role && ((bus_speed == SPD_FULL) || (bus_speed == SPD_LOW));
    dev_case    = !host_role && (bus_speed == SPD_FULL) && lpm_hs;
    filt_active = filt_enabled && (host_case || dev_case);
  end

endmodule

// File: rtl/eopq_se0_run.sv
module eopq_se0_run
  import eopq_pkg::*;
#(
  parameter int RUN_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       watch,
  input  logic [1:0] line_st,
  input  logic       filt_active,
  output logic       accept
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW:0] RUN_MAX = (CW + 1)'(RUN_LEN);

  logic [CW:0] cnt_q;
  logic [CW:0] cnt_d;
  logic [CW:0] cnt_inc;
  logic [CW:0] need;
  logic        is_se0;
  logic        cnt_en;

  assign is_se0 = (line_st == LINE_SE0);

  always_comb begin
    need    = filt_active ? RUN_MAX : (CW + 1)'(1);
    cnt_inc = (cnt_q < RUN_MAX) ? cnt_q + 1'b1 : cnt_q;
    accept  = watch && is_se0 && (cnt_inc >= need);
    if (!watch || !is_se0 || accept) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc;
    end
    cnt_en = watch || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tx_eop_qualifier.sv
module tx_eop_qualifier
  import eopq_pkg::*;
#(
  parameter int CTRL_W    = 32,
  parameter int FILT_BIT  = 29,
  parameter int RUN_LEN   = 2,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_st,
  input  logic              tx_active,
  input  logic              host_role,
  input  logic [1:0]        bus_speed,
  input  logic              lpm_hs,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              eop_pulse,
  output logic              tx_busy
);

  logic rst_sync_n;
  logic filt_active;
  logic eop_accept;
  logic tx_act_q;
  logic busy_q;
  logic busy_d;
  logic eop_q;
  logic eop_d;
  logic tx_start;

  eopq_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  eopq_policy #(.CTRL_W(CTRL_W), .FILT_BIT(FILT_BIT)) u_policy (
    .ctrl_word   (ctrl_word),
    .host_role   (host_role),
    .bus_speed   (bus_speed),
    .lpm_hs      (lpm_hs),
    .filt_active (filt_active)
  );

  eopq_se0_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .watch       (busy_q),
    .line_st     (line_st),
    .filt_active (filt_active),
    .accept      (eop_accept)
  );

  always_comb begin
    tx_start = tx_active && !tx_act_q;
    eop_d    = eop_accept;
    if (eop_accept) begin
      busy_d = 1'b0;
    end else if (tx_start) begin
      busy_d = 1'b1;
    end else begin
      busy_d = busy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_act_q <= 1'b0;
      busy_q   <= 1'b0;
      eop_q    <= 1'b0;
    end else begin
      tx_act_q <= tx_active;
      busy_q   <= busy_d;
      eop_q    <= eop_d;
    end
  end

  assign eop_pulse = eop_q;
  assign tx_busy   = busy_q;

endmodule

// File: rtl/eopq_checker.sv
module eopq_checker #(
  parameter int RUN_LEN = 2
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] line_st,
  input logic       tx_active,
  input logic       filt_active,
  input logic       eop_pulse,
  input logic       tx_busy
);

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eop_pulse |=> !eop_pulse);

  a_r11_busy_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eop_pulse |-> !tx_busy);

  a_r11_fall_needs_eop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(tx_busy) |-> eop_pulse);

  a_r2_rise_on_tx: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tx_busy) |-> $past(tx_active));

  a_r7_se0_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eop_pulse |-> ($past(line_st) == 2'b00));

  a_r12_only_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eop_pulse |-> $past(tx_busy));

  generate
    if (RUN_LEN == 2) begin : g_two
      a_r5_two_samples: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (eop_pulse && $past(filt_active)) |-> ($past(line_st, 2) == 2'b00));
    end
  endgenerate

endmodule

bind tx_eop_qualifier eopq_checker #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .line_st     (line_st),
  .tx_active   (tx_active),
  .filt_active (filt_active),
  .eop_pulse   (eop_pulse),
  .tx_busy     (tx_busy)
);

// File: tb/sim_tx_eop_qualifier.sv
`timescale 1ns/1ps
module sim_tx_eop_qualifier;

  logic        clk;
  logic        rst_n;
  logic [1:0]  line_st;
  logic        tx_active;
  logic        host_role;
  logic [1:0]  bus_speed;
  logic        lpm_hs;
  logic [31:0] ctrl_word;
  logic        eop_pulse;
  logic        tx_busy;

  int tests;
  int fails;
  bit finished;

  tx_eop_qualifier u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_st   (line_st),
    .tx_active (tx_active),
    .host_role (host_role),
    .bus_speed (bus_speed),
    .lpm_hs    (lpm_hs),
    .ctrl_word (ctrl_word),
    .eop_pulse (eop_pulse),
    .tx_busy   (tx_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  function automatic bit filt_rule(input bit en, input bit host, input bit [1:0] spd, input bit lpm);
    bit app;
    app = host ? (spd == 2'b00 || spd == 2'b01) : (spd == 2'b00 && lpm);
    return en && app;
  endfunction

  // one packet: start, n pattern samples, then SE0 until accepted
  task automatic run_trial(input bit en, input bit host, input bit [1:0] spd, input bit lpm,
                           input logic [31:0] other, input int n, input logic [5:0] pat,
                           input string tag);
    int  need;
    int  cnt;
    bit  done;
    bit  fon;
    fon  = filt_rule(en, host, spd, lpm);
    need = fon ? 2 : 1;
    cnt  = 0;
    done = 0;
    @(negedge clk);
    tx_active = 1'b0;
    line_st   = 2'b01;
    host_role = host;
    bus_speed = spd;
    lpm_hs    = lpm;
    ctrl_word = (other & ~(32'h1 << 29)) | (32'(en) << 29);
    @(negedge clk);
    chk("R11 idle busy", int'(tx_busy), 0);
    tx_active = 1'b1;
    @(negedge clk);
    chk("R2 busy set", int'(tx_busy), 1);
    for (int i = 0; i < n + 2; i++) begin
      logic [1:0] c;
      string      t;
      bit         exp_e;
      if (!done) begin
        c = (i < n) ? pat[2*i +: 2] : 2'b00;
        line_st = c;
        @(negedge clk);
        if (c == 2'b00) cnt++;
        else cnt = 0;
        exp_e = (cnt >= need);
        if (tag != "") t = tag;
        else if (exp_e) t = fon ? "R5" : "R3";
        else if (c == 2'b11) t = "R7";
        else if (c == 2'b00) t = "R4";
        else t = "R6";
        chk(t, int'(eop_pulse), int'(exp_e));
        chk("R11 busy", int'(tx_busy), int'(!exp_e));
        if (exp_e) done = 1;
      end
    end
    chk("R5 packet ends", int'(done), 1);
    @(negedge clk);
    line_st = 2'b01;
    chk("R11 pulse width", int'(eop_pulse), 0);
  endtask

  initial begin
    tests = 0; fails = 0; finished = 0;
    rst_n = 1'b0; line_st = 2'b01; tx_active = 1'b0;
    host_role = 1'b1; bus_speed = 2'b00; lpm_hs = 1'b0; ctrl_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", int'(eop_pulse), 0);
    chk("R1 reset busy", int'(tx_busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release busy", int'(tx_busy), 0);
    chk("R1 after release pulse", int'(eop_pulse), 0);

    // R12: SE0 on an idle line
    line_st = 2'b00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 idle pulse", int'(eop_pulse), 0);
      chk("R12 idle busy", int'(tx_busy), 0);
    end

    // R8 host role corners (pattern: SE0 then J)
    run_trial(1, 1, 2'b00, 0, 32'h0, 2, 6'b01_00, "R8");
    run_trial(1, 1, 2'b01, 0, 32'h0, 2, 6'b01_00, "R8");
    run_trial(1, 1, 2'b10, 0, 32'h0, 2, 6'b01_00, "R8");
    run_trial(1, 1, 2'b11, 1, 32'h0, 2, 6'b01_00, "R8");
    // R9 device role corners
    run_trial(1, 0, 2'b00, 1, 32'h0, 2, 6'b01_00, "R9");
    run_trial(1, 0, 2'b00, 0, 32'h0, 2, 6'b01_00, "R9");
    run_trial(1, 0, 2'b01, 1, 32'h0, 2, 6'b01_00, "R9");
    // R10: other bits set, enable clear, and enable alone
    run_trial(0, 1, 2'b00, 0, 32'hFFFF_FFFF, 2, 6'b01_00, "R10");
    run_trial(1, 1, 2'b00, 0, 32'h0, 2, 6'b01_00, "R10");

    // sweep: every config against every three-sample pattern
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int p = 0; p < 64; p++) begin
        logic [31:0] junk;
        junk = 32'hA5C3_96F1 ^ (32'(cfg * 64 + p) * 32'h0100_0193);
        run_trial(cfg[4], cfg[3], cfg[2:1], cfg[0], junk, 3, 6'(p), "");
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule